// File: doc/BRIEF.md
# Exhaustive Key Search Controller

This block runs a brute-force search for the secret key of a 64-bit block cipher with a 128-bit key. A known plaintext and the ciphertext it should produce are captured when a search starts. From then on the block presents one candidate key per clock to an external, fully pipelined encryption engine. The engine has a fixed latency, set by a parameter. Candidates are consecutive integers, beginning at zero. The block never stalls the engine and never inserts an idle slot while a search runs.

Each ciphertext that returns from the engine is compared with the target. The candidate that produced it is recovered from a delay line of the same depth as the engine, so no tag has to travel through the cipher. A valid bit moves along that line, so a returning word is used only if it belongs to a key that was actually issued. On the first match the block stops issuing, raises found and done together, and holds the matching key. If the whole key space is used up without a match, done rises with found low. A synchronous clear abandons any search at any time.

The block does not contain the cipher. It only feeds the engine and judges what comes back.

Top module: `keyHunt`

## Requirements
- R1: While reset is asserted and after it is released, candValid, found and done are low and candKey and keyOut are zero.
- R2: A start pulse in an idle or finished state begins a search. The first candidate is zero, shown with candValid high in the cycle after the start edge. The candidate then rises by exactly one on every clock, and candValid stays high with no gap.
- R3: The start edge captures plainIn and cipherIn. engPlain shows the captured plaintext for the whole search, even if the inputs change later.
- R4: If candidate k is the first whose returning ciphertext equals the target, found and done both rise at the (k+LAT+1)-th rising edge after the start edge, and keyOut equals k. LAT is the engine latency.
- R5: Once found is high, candValid stays low. found, done and keyOut keep their values until a clear or a new start.
- R6: engCipher is ignored in any cycle where no issued candidate is due back from the engine. This covers the first LAT cycles after start and the keys still in flight when a clear occurs.
- R7: If every key up to all ones is issued without a match, candValid drops after the all-ones key. done rises with found low at the (2^KEY_W+LAT)-th rising edge after the start edge, and keyOut stays zero.
- R8: clear acts at the next rising edge and takes priority over start. It drops candValid, found and done, returns candKey and keyOut to zero, and discards every candidate still in flight.
- R9: A start pulse during a running search is ignored. The target, the plaintext and the result are unchanged.
- R10: A start after a finished search clears found and done at the start edge and begins a fresh search from zero with the newly captured pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search with the pair on plainIn and cipherIn |
| clear | input | 1 | Abandon the search and return to idle |
| plainIn | input | BLK_W | Known plaintext, captured at start |
| cipherIn | input | BLK_W | Target ciphertext, captured at start |
| candKey | output | KEY_W | Candidate key to the engine |
| candValid | output | 1 | candKey is a live candidate this cycle |
| engPlain | output | BLK_W | Captured plaintext to the engine |
| engCipher | input | BLK_W | Ciphertext returning from the engine, LAT cycles after its key |
| found | output | 1 | A matching key was found |
| done | output | 1 | The search has ended, with or without a match |
| keyOut | output | KEY_W | The matching key while found is high |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. It counts rising edges from the edge that takes start. Under this count the first candidate is due after edge zero and candidate n after edge n. A match on key k must appear after edge k+LAT+1, and never earlier. An exhausted search must end after edge 2^KEY_W+LAT, which is shown on a narrow 8-bit instance. A clear must take effect one edge after it is driven. The bench holds a forced target ciphertext on the engine input during the first LAT cycles, and leaves real in-flight matches behind a clear, to confirm that nothing is reported before its due edge.

// File: rtl/keyHuntPkg.sv
package keyHuntPkg;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_RUN,
    HS_DRAIN,
    HS_STOP
  } huntState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture plaintext / target
    logic wipe;     // counter and result to zero
    logic flush;    // drop every in-flight valid bit
    logic advance;  // issue current candidate, step the counter
    logic capture;  // latch the key at the tail of the line
  } huntCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic hit;       // tail entry valid and ciphertext equals target
    logic lastKey;   // counter is all ones
    logic onlyTail;  // tail valid, every earlier stage empty
  } huntStat_t;

endpackage

// File: rtl/keyHuntLine.sv
module keyHuntLine #(
  parameter int W     = 128,
  parameter int DEPTH = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inValid,
  input  logic [W-1:0]     inData,
  output logic [DEPTH-1:0] validVec,
  output logic [W-1:0]     outData
);

  for (genvar g = 0; g < DEPTH; g++) begin : gStage
    logic [W-1:0] dataQ;
    logic         validQ;

    if (g == 0) begin : gHead
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dataQ  <= '0;
          validQ <= 1'b0;
        end else begin
          dataQ  <= inData;
          validQ <= flush ? 1'b0 : inValid;
        end
      end
    end else begin : gBody
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dataQ  <= '0;
          validQ <= 1'b0;
        end else begin
          dataQ  <= gStage[g-1].dataQ;
          validQ <= flush ? 1'b0 : gStage[g-1].validQ;
        end
      end
    end

    assign validVec[g] = validQ;
  end

  assign outData = gStage[DEPTH-1].dataQ;

endmodule

// File: rtl/keyHuntPath.sv
module keyHuntPath
  import keyHuntPkg::*;
#(
  parameter int KEY_W = 128,
  parameter int BLK_W = 64,
  parameter int LAT   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  huntCmd_t         cmd,
  input  logic [BLK_W-1:0] plainIn,
  input  logic [BLK_W-1:0] cipherIn,
  input  logic [BLK_W-1:0] engCipher,
  output huntStat_t        stat,
  output logic [KEY_W-1:0] candKey,
  output logic [BLK_W-1:0] engPlain,
  output logic [KEY_W-1:0] keyOut
);

  localparam logic [LAT-1:0]   TAIL_ONLY = LAT'(1) << (LAT - 1);
  localparam logic [KEY_W-1:0] KEY_ONE   = KEY_W'(1);

  logic [KEY_W-1:0] counter;
  logic [BLK_W-1:0] ptReg;
  logic [BLK_W-1:0] ctReg;
  logic [KEY_W-1:0] resultReg;
  logic [LAT-1:0]   lineValid;
  logic [KEY_W-1:0] tailKey;
  logic             tailValid;

  keyHuntLine #(
    .W    (KEY_W),
    .DEPTH(LAT)
  ) u_line (
    .clk     (clk),
    .rstN    (rstN),
    .flush   (cmd.flush),
    .inValid (cmd.advance),
    .inData  (counter),
    .validVec(lineValid),
    .outData (tailKey)
  );

  assign tailValid = lineValid[LAT-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptReg <= '0;
      ctReg <= '0;
    end else if (cmd.load) begin
      ptReg <= plainIn;
      ctReg <= cipherIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      counter   <= '0;
      resultReg <= '0;
    end else if (cmd.wipe) begin
      counter   <= '0;
      resultReg <= '0;
    end else begin
      if (cmd.advance) counter <= counter + KEY_ONE;
      if (cmd.capture) resultReg <= tailKey;
    end
  end

  always_comb begin
    stat.hit      = tailValid && (engCipher == ctReg);
    stat.lastKey  = &counter;
    stat.onlyTail = (lineValid == TAIL_ONLY);
  end

  assign candKey  = counter;
  assign engPlain = ptReg;
  assign keyOut   = resultReg;

endmodule

// File: rtl/keyHuntCtrl.sv
module keyHuntCtrl
  import keyHuntPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      clear,
  input  huntStat_t stat,
  output huntCmd_t  cmd,
  output logic      issue,
  output logic      found,
  output logic      done
);

  huntState_t state, stateNxt;
  logic       foundNxt, doneNxt;
  logic       searching;

  assign searching = (state == HS_RUN) || (state == HS_DRAIN);

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    foundNxt = found;
    doneNxt  = done;
    if (clear) begin
      cmd.wipe  = 1'b1;
      cmd.flush = 1'b1;
      stateNxt  = HS_IDLE;
      foundNxt  = 1'b0;
      doneNxt   = 1'b0;
    end else if (start && !searching) begin
      cmd.load  = 1'b1;
      cmd.wipe  = 1'b1;
      cmd.flush = 1'b1;
      stateNxt  = HS_RUN;
      foundNxt  = 1'b0;
      doneNxt   = 1'b0;
    end else begin
      unique case (state)
        HS_RUN: begin
          cmd.advance = 1'b1;
          if (stat.hit) begin
            cmd.capture = 1'b1;
            cmd.flush   = 1'b1;
            stateNxt    = HS_STOP;
            foundNxt    = 1'b1;
            doneNxt     = 1'b1;
          end else if (stat.lastKey) begin
            stateNxt = HS_DRAIN;
          end
        end
        HS_DRAIN: begin
          if (stat.hit) begin
            cmd.capture = 1'b1;
            cmd.flush   = 1'b1;
            stateNxt    = HS_STOP;
            foundNxt    = 1'b1;
            doneNxt     = 1'b1;
          end else if (stat.onlyTail) begin
            cmd.flush = 1'b1;
            stateNxt  = HS_STOP;
            doneNxt   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= HS_IDLE;
      found <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      found <= foundNxt;
      done  <= doneNxt;
    end
  end

  assign issue = (state == HS_RUN);

endmodule

// File: rtl/keyHunt.sv
module keyHunt
  import keyHuntPkg::*;
#(
  parameter int KEY_W = 128,
  parameter int BLK_W = 64,
  parameter int LAT   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             clear,
  input  logic [BLK_W-1:0] plainIn,
  input  logic [BLK_W-1:0] cipherIn,
  output logic [KEY_W-1:0] candKey,
  output logic             candValid,
  output logic [BLK_W-1:0] engPlain,
  input  logic [BLK_W-1:0] engCipher,
  output logic             found,
  output logic             done,
  output logic [KEY_W-1:0] keyOut
);

  huntCmd_t  cmd;
  huntStat_t stat;

  keyHuntCtrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .clear(clear),
    .stat (stat),
    .cmd  (cmd),
    .issue(candValid),
    .found(found),
    .done (done)
  );

  keyHuntPath #(
    .KEY_W(KEY_W),
    .BLK_W(BLK_W),
    .LAT  (LAT)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .plainIn  (plainIn),
    .cipherIn (cipherIn),
    .engCipher(engCipher),
    .stat     (stat),
    .candKey  (candKey),
    .engPlain (engPlain),
    .keyOut   (keyOut)
  );

endmodule

// File: rtl/keyHuntChecker.sv
module keyHuntChecker #(
  parameter int KEY_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             clear,
  input logic [KEY_W-1:0] candKey,
  input logic             candValid,
  input logic             found,
  input logic             done,
  input logic [KEY_W-1:0] keyOut
);

  AST_FIRST_KEY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(candValid) |-> candKey == '0); // R2

  AST_KEY_STEP: assert property (@(posedge clk) disable iff (!rstN)
    candValid && $past(candValid) |-> candKey == $past(candKey) + KEY_W'(1)); // R2

  AST_FOUND_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rstN)
    found |-> done); // R4

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !candValid); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    found && !start && !clear |=> found && $stable(keyOut)); // R5

  AST_EXHAUST_KEY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    done && !found |-> keyOut == '0); // R7

  AST_CLEAR_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !candValid && !found && !done && candKey == '0); // R8

endmodule

bind keyHunt keyHuntChecker #(.KEY_W(KEY_W)) u_keyHuntChecker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .clear    (clear),
  .candKey  (candKey),
  .candValid(candValid),
  .found    (found),
  .done     (done),
  .keyOut   (keyOut)
);

// File: tb/test_keyHunt.sv
module engineModel #(
  parameter int KW  = 128,
  parameter int LAT = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [KW-1:0] key,
  input  logic [63:0]   plain,
  output logic [63:0]   cipher
);
  logic [63:0] pipe [LAT];

  function automatic logic [63:0] mix(input logic [KW-1:0] k, input logic [63:0] p);
    logic [127:0] wide;
    wide = 128'(k);
    return p ^ wide[63:0] ^ wide[127:64];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= mix(key, plain);
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign cipher = pipe[LAT-1];
endmodule

module test_keyHunt;
  localparam int KW   = 128;
  localparam int LAT  = 6;
  localparam int NKW  = 8;
  localparam int NLAT = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN, start, clear;
  logic [63:0]   plainIn, cipherIn, engPlain, engOut, engCipher, forceVal;
  logic          forceOn;
  logic [KW-1:0] candKey, keyOut;
  logic          candValid, found, done;

  logic           nStart, nClear;
  logic [63:0]    nPlain, nCipher, nEngPlain, nEngCipher;
  logic [NKW-1:0] nCandKey, nKeyOut;
  logic           nCandValid, nFound, nDone;

  int total = 0;
  int bad   = 0;

  assign engCipher = forceOn ? forceVal : engOut;

  keyHunt #(.KEY_W(KW), .BLK_W(64), .LAT(LAT)) i_keyHunt (
    .clk(clk), .rstN(rstN), .start(start), .clear(clear),
    .plainIn(plainIn), .cipherIn(cipherIn),
    .candKey(candKey), .candValid(candValid), .engPlain(engPlain),
    .engCipher(engCipher), .found(found), .done(done), .keyOut(keyOut));

  engineModel #(.KW(KW), .LAT(LAT)) i_engine (
    .clk(clk), .rstN(rstN), .key(candKey), .plain(engPlain), .cipher(engOut));

  keyHunt #(.KEY_W(NKW), .BLK_W(64), .LAT(NLAT)) i_keyHuntNarrow (
    .clk(clk), .rstN(rstN), .start(nStart), .clear(nClear),
    .plainIn(nPlain), .cipherIn(nCipher),
    .candKey(nCandKey), .candValid(nCandValid), .engPlain(nEngPlain),
    .engCipher(nEngCipher), .found(nFound), .done(nDone), .keyOut(nKeyOut));

  engineModel #(.KW(NKW), .LAT(NLAT)) i_engineNarrow (
    .clk(clk), .rstN(rstN), .key(nCandKey), .plain(nEngPlain), .cipher(nEngCipher));

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; start = 1'b0; clear = 1'b0; forceOn = 1'b0; forceVal = '0;
    plainIn = '0; cipherIn = '0;
    nStart = 1'b0; nClear = 1'b0; nPlain = '0; nCipher = '0;
    repeat (3) @(negedge clk);
    chk("R1", "candValid in reset", candValid, 0);
    chk("R1", "found in reset", found, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "candValid after reset", candValid, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "candKey after reset", candKey, 0);
    chk("R1", "keyOut after reset", keyOut, 0);
  endtask

  // search whose first match is key pt^ct; optionally drives the target
  // onto the engine port before any key can be due back
  task automatic t_search(input logic [63:0] pt, input logic [63:0] ct, input bit forceEarly);
    logic [127:0] kExp;
    int           dueAt;
    bit           early;
    kExp  = {64'b0, pt ^ ct};
    dueAt = int'(kExp) + LAT + 1;
    early = 1'b0;
    forceVal = ct;
    forceOn  = forceEarly;
    @(negedge clk);
    plainIn = pt; cipherIn = ct; start = 1'b1;
    @(negedge clk);
    start = 1'b0; plainIn = ~pt; cipherIn = ~ct;
    chk("R2", "first candidate valid", candValid, 1);
    chk("R2", "first candidate zero", candKey, 0);
    chk("R10", "found cleared by start", found, 0);
    chk("R10", "done cleared by start", done, 0);
    for (int e = 1; e <= dueAt; e++) begin
      @(negedge clk);
      if (e == LAT) forceOn = 1'b0;
      if (e == 1) chk("R3", "plaintext held", engPlain, pt);
      if (e <= int'(kExp) && e <= 8) chk("R2", "candidate step", candKey, 128'(e));
      if (e < dueAt && (found || done)) early = 1'b1;
    end
    chk(forceEarly ? "R6" : "R4", "result before due edge", early, 0);
    chk("R4", "found at due edge", found, 1);
    chk("R4", "done at due edge", done, 1);
    chk("R4", "matching key", keyOut, kExp);
    chk("R5", "issue stopped", candValid, 0);
    repeat (3) @(negedge clk);
    chk("R5", "found held", found, 1);
    chk("R5", "key held", keyOut, kExp);
    chk("R5", "issue still stopped", candValid, 0);
  endtask

  task automatic t_clear();
    logic [63:0] pt;
    bit          late;
    pt   = 64'h0000_1234_0000_5678;
    late = 1'b0;
    @(negedge clk);
    plainIn = pt; cipherIn = pt ^ 64'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int e = 1; e <= 4; e++) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk("R8", "candValid after clear", candValid, 0);
    chk("R8", "candKey after clear", candKey, 0);
    chk("R8", "found after clear", found, 0);
    chk("R8", "done after clear", done, 0);
    chk("R8", "keyOut after clear", keyOut, 0);
    // key 3 is still in the engine and returns the target after the clear
    for (int e = 0; e < 2 * LAT; e++) begin
      @(negedge clk);
      if (found || done || candValid) late = 1'b1;
    end
    chk("R6", "in-flight match ignored after clear", late, 0);
  endtask

  task automatic t_startIgnored();
    logic [63:0] pt;
    int          dueAt;
    pt    = 64'h00AB_C000_0000_0000;
    dueAt = 20 + LAT + 1;
    @(negedge clk);
    plainIn = pt; cipherIn = pt ^ 64'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int e = 1; e <= dueAt; e++) begin
      @(negedge clk);
      if (e == 5) begin start = 1'b1; plainIn = '0; cipherIn = 64'd2; end
      if (e == 6) start = 1'b0;
      if (e == 8) chk("R9", "plaintext kept", engPlain, pt);
      if (e == 8) chk("R9", "search still counting", candKey, 8);
    end
    chk("R9", "found with original target", found, 1);
    chk("R9", "original key reported", keyOut, 20);
  endtask

  task automatic t_exhaust();
    int dueAt;
    bit early;
    dueAt = (1 << NKW) + NLAT;
    early = 1'b0;
    @(negedge clk);
    nPlain = '0; nCipher = 64'h0001_0000; nStart = 1'b1;
    @(negedge clk);
    nStart = 1'b0;
    for (int e = 1; e <= dueAt; e++) begin
      @(negedge clk);
      if (e == (1 << NKW) - 1) chk("R7", "all-ones key issued", {nCandValid, nCandKey}, {1'b1, 8'hFF});
      if (e == (1 << NKW)) chk("R7", "issue stops after all ones", nCandValid, 0);
      if (e < dueAt && nDone) early = 1'b1;
    end
    chk("R7", "done before due edge", early, 0);
    chk("R7", "done after exhaustion", nDone, 1);
    chk("R7", "found low after exhaustion", nFound, 0);
    chk("R7", "key zero after exhaustion", nKeyOut, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_search(64'h00A5_00A5_00A5_00A5, 64'h00A5_00A5_00A5_00A5, 1'b0);
    t_search(64'h1357_9BDF_0000_0100, 64'h1357_9BDF_0000_0105, 1'b0);
    t_search(64'h0F0F_0000_2222_0000, 64'h0F0F_0000_2222_000A, 1'b1);
    t_search(64'h4444_0000_0000_0000, 64'h4444_0000_0000_0028, 1'b0);
    t_clear();
    t_startIgnored();
    t_exhaust();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule